// File: doc/BRIEF.md
# Double-Data-Rate 4:2:2 Video Input Demultiplexer

This block accepts a 4:2:2 luma/chroma pixel stream in which both components share one 10-bit bus. The bus carries one word on the rising edge of the pixel clock and another on the falling edge. The block samples the bus on both edges and pairs each chroma word with the luma word that follows it in time. It then delivers one parallel luma word and one chroma word per rising edge in the single-rate clock domain. A 2-bit configuration input selects whether luma travels on the rising edge or on the falling edge.

While it separates the words, the block scans the paired stream for embedded timing reference codes. Each code is made of a preamble of all-ones, zero and zero, followed by a status word. A start-of-active-video or end-of-active-video code raises a single-cycle pulse. The field and vertical-blank flags in the status word are held on dedicated outputs. The chroma output is tagged as Cb or Cr, and the tag restarts at Cb after every start-of-active-video code. The bus can be read as a full 10-bit word or as an 8-bit word in its upper bits.

Top module: `ddr422_demux`

## Requirements
- R1: With `luma_sel` = 2'b11, the luma of a pair is the word sampled on a rising edge, and its chroma is the word sampled on the falling edge just before it.
- R2: With `luma_sel` equal to 2'b00, 2'b01 or 2'b10, the chroma of a pair is the word sampled on a rising edge, and its luma is the word sampled on the falling edge just after it.
- R3: A pair whose rising-edge word is sampled on rising edge k appears on `y_out`/`c_out` after rising edge k+2. Exactly one pair appears per clock cycle.
- R4: With `wide_en` = 0, bits [1:0] of `y_out` and `c_out` are zero, and every reference-code comparison looks only at bits [9:2]. With `wide_en` = 1, all ten bits pass through and are compared.
- R5: A pair with chroma all-ones and luma zero, followed directly by a pair with chroma zero, makes a reference code whose status word is that second luma. In the output cycle of that second pair, `sav_pulse` is high if status bit 6 is 0, and `eav_pulse` is high if status bit 6 is 1. Each pulse lasts one cycle, and the two pulses are never high together.
- R6: A preamble that breaks off (for example a second-pair chroma that is not zero, or a 10-bit word of 0x3FE) raises no pulse. Its words pass to the outputs as ordinary pixel data.
- R7: On every detected reference code, `field_o` takes status bit 8 and `vblank_o` takes status bit 7. At all other times both outputs hold their values.
- R8: `c_is_cr` (0 = Cb, 1 = Cr) inverts on every output cycle. The exception is the cycle after a `sav_pulse`, where it is 0.
- R9: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; the bus is sampled on both edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 10 | Shared double-data-rate luma/chroma bus |
| luma_sel | input | 2 | 2'b11: luma on rising edge; other values: luma on falling edge |
| wide_en | input | 1 | 1: 10-bit words; 0: 8-bit words in bits [9:2] |
| y_out | output | 10 | Luma word of the current pair |
| c_out | output | 10 | Chroma word of the current pair |
| c_is_cr | output | 1 | Chroma component tag: 0 = Cb, 1 = Cr |
| sav_pulse | output | 1 | Single-cycle start-of-active-video marker |
| eav_pulse | output | 1 | Single-cycle end-of-active-video marker |
| field_o | output | 1 | Field flag from the last reference code |
| vblank_o | output | 1 | Vertical-blank flag from the last reference code |

## Verification
On every cycle, the assertions check several properties. Start and end pulses never overlap and never last two cycles. The chroma tag alternates and restarts at Cb after a start code. The field and blank flags move only in a pulse cycle. In 8-bit mode, the two low output bits stay zero. Other behaviours can only be shown by the bench's scenarios comparing the ports against a stream model: which edge's word lands in which output, the two-cycle alignment, recognition of a complete preamble against a broken one, and the masked comparison in 8-bit mode. These scenarios cover all four `luma_sel` encodings in both widths.

// File: rtl/ddr422_pkg.sv
package ddr422_pkg;
    localparam int          PIX_W        = 10;
    localparam int          NARROW_W     = 8;
    localparam logic [1:0]  LUMA_ON_RISE = 2'b11;
endpackage

// File: rtl/ddr_pair_capture.sv
module ddr_pair_capture
    import ddr422_pkg::*;
#(
    parameter int DATA_W = PIX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [1:0]        luma_sel,
    output logic [DATA_W-1:0] pair_y,
    output logic [DATA_W-1:0] pair_c
);
    typedef struct packed {
        logic [DATA_W-1:0] rise;
        logic [DATA_W-1:0] fall_old;
        logic [DATA_W-1:0] y;
        logic [DATA_W-1:0] c;
    } cap_t;

    logic [DATA_W-1:0] fall_q;
    cap_t              cap_d;
    cap_t              cap_q;

    // Falling-edge sample of the shared bus
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= bus_in;
    end

    always_comb begin
        cap_d          = cap_q;
        cap_d.rise     = bus_in;
        cap_d.fall_old = fall_q;
        if (luma_sel == LUMA_ON_RISE) begin
            // chroma came half a cycle before the rising-edge luma
            cap_d.y = cap_q.rise;
            cap_d.c = cap_q.fall_old;
        end else begin
            // chroma on the rising edge, luma on the falling edge after it
            cap_d.c = cap_q.rise;
            cap_d.y = fall_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign pair_y = cap_q.y;
    assign pair_c = cap_q.c;
endmodule

// File: rtl/pair_decode.sv
module pair_decode
    import ddr422_pkg::*;
#(
    parameter int DATA_W   = PIX_W,
    parameter int NAR_W    = NARROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pair_y,
    input  logic [DATA_W-1:0] pair_c,
    input  logic              wide_en,
    output logic [DATA_W-1:0] y_out,
    output logic [DATA_W-1:0] c_out,
    output logic              c_is_cr,
    output logic              sav_pulse,
    output logic              eav_pulse,
    output logic              field_o,
    output logic              vblank_o
);
    localparam int LOW_W = DATA_W - NAR_W;
    localparam int F_POS = DATA_W - 2;
    localparam int V_POS = DATA_W - 3;
    localparam int H_POS = DATA_W - 4;

    typedef struct packed {
        logic [DATA_W-1:0] prev_y;
        logic [DATA_W-1:0] prev_c;
        logic [DATA_W-1:0] y;
        logic [DATA_W-1:0] c;
        logic              phase;
        logic              cr;
        logic              sav;
        logic              eav;
        logic              fld;
        logic              vbl;
    } dec_t;

    dec_t              dec_d;
    dec_t              dec_q;
    logic [DATA_W-1:0] msk;
    logic              pre_ok;
    logic              code_hit;

    always_comb begin
        msk = wide_en ? {DATA_W{1'b1}} : {{NAR_W{1'b1}}, {LOW_W{1'b0}}};
        pre_ok   = ((dec_q.prev_c & msk) == msk) && ((dec_q.prev_y & msk) == '0);
        code_hit = pre_ok && ((pair_c & msk) == '0);

        dec_d        = dec_q;
        dec_d.prev_y = pair_y;
        dec_d.prev_c = pair_c;
        dec_d.y      = pair_y & msk;
        dec_d.c      = pair_c & msk;
        dec_d.sav    = code_hit && !pair_y[H_POS];
        dec_d.eav    = code_hit &&  pair_y[H_POS];
        if (code_hit) begin
            dec_d.fld = pair_y[F_POS];
            dec_d.vbl = pair_y[V_POS];
        end
        dec_d.cr    = dec_q.phase;
        dec_d.phase = dec_d.sav ? 1'b0 : ~dec_q.phase;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q       <= '0;
            dec_q.phase <= 1'b1;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign y_out     = dec_q.y;
    assign c_out     = dec_q.c;
    assign c_is_cr   = dec_q.cr;
    assign sav_pulse = dec_q.sav;
    assign eav_pulse = dec_q.eav;
    assign field_o   = dec_q.fld;
    assign vblank_o  = dec_q.vbl;
endmodule

// File: rtl/ddr422_demux.sv
module ddr422_demux
    import ddr422_pkg::*;
#(
    parameter int DATA_W = PIX_W,
    parameter int NAR_W  = NARROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [1:0]        luma_sel,
    input  logic              wide_en,
    output logic [DATA_W-1:0] y_out,
    output logic [DATA_W-1:0] c_out,
    output logic              c_is_cr,
    output logic              sav_pulse,
    output logic              eav_pulse,
    output logic              field_o,
    output logic              vblank_o
);
    logic [DATA_W-1:0] pair_y;
    logic [DATA_W-1:0] pair_c;

    ddr_pair_capture #(.DATA_W(DATA_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_in   (bus_in),
        .luma_sel (luma_sel),
        .pair_y   (pair_y),
        .pair_c   (pair_c)
    );

    pair_decode #(.DATA_W(DATA_W), .NAR_W(NAR_W)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .pair_y    (pair_y),
        .pair_c    (pair_c),
        .wide_en   (wide_en),
        .y_out     (y_out),
        .c_out     (c_out),
        .c_is_cr   (c_is_cr),
        .sav_pulse (sav_pulse),
        .eav_pulse (eav_pulse),
        .field_o   (field_o),
        .vblank_o  (vblank_o)
    );
endmodule

// File: rtl/ddr422_demux_chk.sv
module ddr422_demux_chk #(
    parameter int DATA_W = 10,
    parameter int NAR_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wide_en,
    input logic [DATA_W-1:0] y_out,
    input logic [DATA_W-1:0] c_out,
    input logic              c_is_cr,
    input logic              sav_pulse,
    input logic              eav_pulse,
    input logic              field_o,
    input logic              vblank_o
);
    localparam int LOW_W = DATA_W - NAR_W;

    assert_marks_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sav_pulse && eav_pulse));

    assert_sav_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sav_pulse |=> !sav_pulse);

    assert_eav_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eav_pulse |=> !eav_pulse);

    assert_cb_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sav_pulse |=> !c_is_cr);

    assert_tag_alternates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sav_pulse |=> (c_is_cr != $past(c_is_cr)));

    assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sav_pulse && !eav_pulse) |-> $stable({field_o, vblank_o}));

    assert_narrow_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wide_en) |-> (y_out[LOW_W-1:0] == '0 && c_out[LOW_W-1:0] == '0));
endmodule

bind ddr422_demux ddr422_demux_chk #(.DATA_W(DATA_W), .NAR_W(NAR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wide_en   (wide_en),
    .y_out     (y_out),
    .c_out     (c_out),
    .c_is_cr   (c_is_cr),
    .sav_pulse (sav_pulse),
    .eav_pulse (eav_pulse),
    .field_o   (field_o),
    .vblank_o  (vblank_o)
);

// File: tb/ddr422_demux_bench.sv
`timescale 1ns/1ps
module ddr422_demux_bench;
    localparam int N  = 160;
    localparam int NA = N + 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] bus_in = '0;
    logic [1:0] luma_sel = 2'b11;
    logic       wide_en = 1'b1;
    logic [9:0] y_out, c_out;
    logic       c_is_cr, sav_pulse, eav_pulse, field_o, vblank_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [9:0] pc [0:NA-1];
    logic [9:0] py [0:NA-1];
    logic       esav [0:NA-1];
    logic       eeav [0:NA-1];

    always #2.5 clk = ~clk;

    ddr422_demux u_ddr422_demux (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .luma_sel(luma_sel),
        .wide_en(wide_en), .y_out(y_out), .c_out(c_out), .c_is_cr(c_is_cr),
        .sav_pulse(sav_pulse), .eav_pulse(eav_pulse),
        .field_o(field_o), .vblank_o(vblank_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [9:0] msk(input logic w);
        return w ? 10'h3FF : 10'h3FC;
    endfunction

    function automatic logic is_code(input int j, input logic w);
        if (j < 1) return 1'b0;
        return ((pc[j-1] & msk(w)) == msk(w)) && ((py[j-1] & msk(w)) == 10'h000)
               && ((pc[j] & msk(w)) == 10'h000);
    endfunction

    function automatic logic [9:0] rise_word(input int i, input logic [1:0] sel);
        return (sel == 2'b11) ? py[i] : pc[i];
    endfunction

    function automatic logic [9:0] fall_word(input int i, input logic [1:0] sel);
        return (sel == 2'b11) ? pc[i+1] : py[i];
    endfunction

    task automatic build_stream(input logic w);
        int j;
        for (int k = 0; k < NA; k++) begin pc[k] = '0; py[k] = '0; end
        j = 1;
        while (j < N) begin
            int pick;
            pick = $urandom_range(0, 9);
            if (pick == 0 && j + 1 < N) begin
                pc[j]   = w ? 10'h3FF : (10'h3FC | 10'($urandom_range(0, 3)));
                py[j]   = w ? 10'h000 : 10'($urandom_range(0, 3));
                pc[j+1] = w ? 10'h000 : 10'($urandom_range(0, 3));
                py[j+1] = {1'b1, 3'($urandom), 6'($urandom)};
                j += 2;
            end else if (pick == 1 && j + 1 < N) begin
                // R6 broken preamble: second chroma not zero
                pc[j]   = 10'h3FF;
                py[j]   = 10'h000;
                pc[j+1] = 10'h010 | 10'($urandom_range(0, 3));
                py[j+1] = 10'($urandom);
                j += 2;
            end else if (pick == 2 && w && j + 1 < N) begin
                // R6 near-miss only in 10-bit mode
                pc[j]   = 10'h3FE;
                py[j]   = 10'h000;
                pc[j+1] = 10'h000;
                py[j+1] = 10'h200;
                j += 2;
            end else begin
                pc[j] = 10'($urandom);
                py[j] = 10'($urandom);
                j += 1;
            end
        end
        for (int k = 0; k < NA; k++) begin
            esav[k] = is_code(k, w) && !py[k][6];
            eeav[k] = is_code(k, w) &&  py[k][6];
        end
    endtask

    task automatic run_scenario(input logic [1:0] sel, input logic w);
        logic ph, fexp, vexp, outcr, s;
        string dreq;
        dreq = (sel == 2'b11) ? "R1 R3 R4" : "R2 R3 R4";
        build_stream(w);
        rst_n = 1'b0;
        bus_in = '0;
        luma_sel = sel;
        wide_en = w;
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset data", {22'd0, y_out}, 32'd0);
        check("R9 reset chroma", {22'd0, c_out}, 32'd0);
        check("R9 reset flags", {27'd0, c_is_cr, sav_pulse, eav_pulse, field_o, vblank_o}, 32'd0);
        @(negedge clk);
        #1.25;
        rst_n = 1'b1;
        bus_in = rise_word(0, sel);
        ph = 1'b1; fexp = 1'b0; vexp = 1'b0;
        for (int i = 0; i < N + 2; i++) begin
            @(posedge clk);
            outcr = ph;
            s = (i >= 2) ? esav[i-2] : 1'b0;
            if (i >= 2 && (esav[i-2] || eeav[i-2])) begin
                fexp = py[i-2][8];
                vexp = py[i-2][7];
            end
            ph = s ? 1'b0 : ~ph;
            #1;
            if (i >= 2) begin
                check(dreq, {22'd0, y_out}, {22'd0, py[i-2] & msk(w)});
                check(dreq, {22'd0, c_out}, {22'd0, pc[i-2] & msk(w)});
                check("R5/R6 pulses", {30'd0, sav_pulse, eav_pulse}, {30'd0, esav[i-2], eav_dummy(i-2)});
                check("R7 flags", {30'd0, field_o, vblank_o}, {30'd0, fexp, vexp});
            end
            check("R8 chroma tag", {31'd0, c_is_cr}, {31'd0, outcr});
            #0.25;
            bus_in = fall_word(i, sel);
            @(negedge clk);
            #1.25;
            bus_in = rise_word(i + 1, sel);
        end
    endtask

    function automatic logic eav_dummy(input int j);
        return eeav[j];
    endfunction

    initial begin
        void'($urandom(32'd20240607));
        run_scenario(2'b11, 1'b1);
        run_scenario(2'b00, 1'b1);
        run_scenario(2'b01, 1'b1);
        run_scenario(2'b10, 1'b1);
        run_scenario(2'b11, 1'b0);
        run_scenario(2'b00, 1'b0);
        run_scenario(2'b10, 1'b0);
        run_scenario(2'b01, 1'b0);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(5 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule